// File: doc/BRIEF.md
# Disk Interface Channel Configuration Port

This block is the configuration front end of an integrated disk-interface controller. Software reaches it through three byte-wide I/O ports. The first is a free read/write chip-identification byte. The second is an index register. The third is a data window onto an indexed bank of 256 configuration bytes. Two of those bytes decide whether the primary and secondary disk channels are switched on.

When a channel is on, the block flags every I/O access that falls inside that channel's command-block window (eight consecutive addresses) or on its control-block address. The drive protocol behind those flags is handled elsewhere.

Channel enables are held in a small state machine with three states:
- `CH_OFF`: no channel is on.
- `CH_PRI`: only the primary channel is on.
- `CH_BOTH`: both channels are on.

The state moves only on a data-port write. On each such write it first drops every channel and then re-evaluates both, using the bank contents that include the byte being written. The named transitions are:
- `T_PRI_DROP` (to `CH_OFF`): the primary bit is clear.
- `T_SEC_MASKED` (to `CH_PRI`): the primary bit is set, but the secondary mask test fails.
- `T_DUAL` (to `CH_BOTH`): the primary bit is set and the secondary mask test passes.

Without a data write the state is held (`T_HOLD`).

Top module: `dcc_port_top`

## Requirements
- R1: After reset, both channel enables are 0 and the chip-ID byte is 0x00. The indexed bank holds 0x02 at index 0x01, 0xFF at 0x08, 0x41 at 0x09, 0xFF at 0x34, 0x01 at 0x35, and 0x00 everywhere else.
- R2: A write to I/O address 0x00F4 stores the chip-ID byte, and a read of 0x00F4 returns it.
- R3: A write to I/O address 0x00F8 selects the index. A read of 0x00F8 always returns 0xFF.
- R4: A write to I/O address 0x00FC stores the byte at the current index, and a read of 0x00FC returns the byte at the current index.
- R5: The primary enable becomes bit 0 of the byte at index 0x01. It takes its new value at the rising edge that captures the data-port write.
- R6: The secondary enable is 1 only when the primary enable is 1 and (byte at index 0x35 AND 0x41) equals 0x00.
- R7: Writes to the chip-ID or index port, and all reads, leave both channel enables unchanged.
- R8: While the primary channel is on, an access (read or write strobe) to 0x01F0..0x01F7 raises the primary command select, and an access to 0x03F6 raises the primary control select. Otherwise both are 0.
- R9: While the secondary channel is on, an access to 0x0170..0x0177 raises the secondary command select, and an access to 0x0376 raises the secondary control select. Otherwise both are 0.
- R10: A read of any address other than the three configuration ports returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O address |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data (combinational) |
| pri_en | output | 1 | Primary channel enabled |
| sec_en | output | 1 | Secondary channel enabled |
| pri_cmd_cs | output | 1 | Access hits the primary command window |
| pri_ctl_cs | output | 1 | Access hits the primary control address |
| sec_cmd_cs | output | 1 | Access hits the secondary command window |
| sec_ctl_cs | output | 1 | Access hits the secondary control address |

## Verification
The hardest case to reach from the ports is the secondary channel being dropped while its own mask byte is unchanged. The stimulus first reaches `CH_BOTH`. It then clears the primary bit and checks that the secondary enable falls at the same edge. After that it sets the primary bit again without touching index 0x35, and checks that the secondary channel comes back only through the full re-evaluation. Mask values 0x40 and 0xBE confirm that only bits 6 and 0 of index 0x35 matter.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

    typedef enum logic [1:0] {
        CH_OFF  = 2'd0,
        CH_PRI  = 2'd1,
        CH_BOTH = 2'd2
    } chan_state_e;

    localparam int NCHAN = 2;

    // Index of the byte holding the primary enable bit, and of the secondary mask byte
    localparam logic [7:0] IDX_PRI_CFG = 8'h01;
    localparam logic [7:0] IDX_SEC_CFG = 8'h35;
    localparam logic [7:0] SEC_BLOCK_MASK = 8'h41;

    function automatic logic [15:0] cmd_base(input int ch);
        return (ch == 0) ? 16'h01F0 : 16'h0170;
    endfunction

    function automatic logic [15:0] ctl_addr(input int ch);
        return (ch == 0) ? 16'h03F6 : 16'h0376;
    endfunction

    function automatic logic [7:0] reg_default(input int idx);
        case (idx)
            8'h01:   return 8'h02;
            8'h08:   return 8'hFF;
            8'h09:   return 8'h41;
            8'h34:   return 8'hFF;
            8'h35:   return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/dcc_regbank.sv
module dcc_regbank
    import dcc_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_wr,
    input  logic              data_wr,
    input  logic              id_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] data_q,
    output logic [DATA_W-1:0] chip_id_q,
    output logic [DATA_W-1:0] pri_cfg_nxt,
    output logic [DATA_W-1:0] sec_cfg_nxt
);
    localparam int NREGS = 1 << IDX_W;

    logic [IDX_W-1:0]  index_q;
    logic [DATA_W-1:0] bank [NREGS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index_q   <= '0;
            chip_id_q <= '0;
            for (int i = 0; i < NREGS; i++) begin
                bank[i] <= DATA_W'(reg_default(i));
            end
        end else begin
            if (idx_wr) begin
                index_q <= wdata[IDX_W-1:0];
            end
            if (id_wr) begin
                chip_id_q <= wdata;
            end
            if (data_wr) begin
                bank[index_q] <= wdata;
            end
        end
    end

    assign data_q = bank[index_q];

    // View of the two configuration bytes including a write in flight
    always_comb begin
        pri_cfg_nxt = bank[IDX_PRI_CFG[IDX_W-1:0]];
        sec_cfg_nxt = bank[IDX_SEC_CFG[IDX_W-1:0]];
        if (data_wr && index_q == IDX_PRI_CFG[IDX_W-1:0]) begin
            pri_cfg_nxt = wdata;
        end
        if (data_wr && index_q == IDX_SEC_CFG[IDX_W-1:0]) begin
            sec_cfg_nxt = wdata;
        end
    end

    // R2: chip ID changes only through its own port
    p_chipid_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !id_wr |=> $stable(chip_id_q));

    // R3: index changes only through its own port
    p_index_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !idx_wr |=> $stable(index_q));

endmodule

// File: rtl/dcc_chan_fsm.sv
module dcc_chan_fsm
    import dcc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] pri_cfg_nxt,
    input  logic [DATA_W-1:0] sec_cfg_nxt,
    output logic              pri_en,
    output logic              sec_en
);
    chan_state_e state_q, state_d;
    logic pri_ok, sec_ok;

    assign pri_ok = pri_cfg_nxt[0];
    assign sec_ok = ((sec_cfg_nxt & DATA_W'(SEC_BLOCK_MASK)) == '0);

    // Next state: drop all channels, then re-evaluate on every data write
    always_comb begin
        state_d = state_q;                        // T_HOLD
        if (data_wr) begin
            unique case ({pri_ok, sec_ok})
                2'b11:        state_d = CH_BOTH;  // T_DUAL
                2'b10:        state_d = CH_PRI;   // T_SEC_MASKED
                2'b00, 2'b01: state_d = CH_OFF;   // T_PRI_DROP
                default:      state_d = CH_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            CH_OFF:  begin pri_en = 1'b0; sec_en = 1'b0; end
            CH_PRI:  begin pri_en = 1'b1; sec_en = 1'b0; end
            CH_BOTH: begin pri_en = 1'b1; sec_en = 1'b1; end
            default: begin pri_en = 1'b0; sec_en = 1'b0; end
        endcase
    end

    // R6: secondary never on without primary
    p_sec_needs_pri_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sec_en |-> pri_en);

    // R7: state moves only after a data write
    p_hold_without_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !data_wr |=> $stable(state_q));

    // R5: primary can only rise from a data write
    p_pri_rise_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pri_en) |-> $past(data_wr));

endmodule

// File: rtl/dcc_chan_decode.sv
module dcc_chan_decode #(
    parameter int              ADDR_W   = 16,
    parameter int              SPAN_LOG = 3,
    parameter logic [ADDR_W-1:0] CMD_BASE = 16'h01F0,
    parameter logic [ADDR_W-1:0] CTL_ADDR = 16'h03F6
) (
    input  logic              en,
    input  logic              access,
    input  logic [ADDR_W-1:0] addr,
    output logic              cmd_cs,
    output logic              ctl_cs
);
    logic in_cmd, in_ctl;

    assign in_cmd = (addr[ADDR_W-1:SPAN_LOG] == CMD_BASE[ADDR_W-1:SPAN_LOG]);
    assign in_ctl = (addr == CTL_ADDR);
    assign cmd_cs = en && access && in_cmd;
    assign ctl_cs = en && access && in_ctl;

    // R8/R9: a select implies an access strobe
    always_comb begin
        p_cs_needs_access_r8: assert (!(cmd_cs || ctl_cs) || access);
    end

endmodule

// File: rtl/dcc_port_top.sv
module dcc_port_top
    import dcc_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter int              DATA_W    = 8,
    parameter int              IDX_W     = 8,
    parameter int              SPAN_LOG  = 3,
    parameter logic [15:0]     ID_PORT   = 16'h00F4,
    parameter logic [15:0]     IDX_PORT  = 16'h00F8,
    parameter logic [15:0]     DATA_PORT = 16'h00FC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    output logic              pri_en,
    output logic              sec_en,
    output logic              pri_cmd_cs,
    output logic              pri_ctl_cs,
    output logic              sec_cmd_cs,
    output logic              sec_ctl_cs
);
    logic hit_id, hit_idx, hit_data;
    logic [DATA_W-1:0] data_q, chip_id_q, pri_cfg_nxt, sec_cfg_nxt;
    logic [NCHAN-1:0] en_vec, cmd_vec, ctl_vec;

    assign hit_id   = (io_addr == ADDR_W'(ID_PORT));
    assign hit_idx  = (io_addr == ADDR_W'(IDX_PORT));
    assign hit_data = (io_addr == ADDR_W'(DATA_PORT));

    dcc_regbank #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx_wr     (io_wr && hit_idx),
        .data_wr    (io_wr && hit_data),
        .id_wr      (io_wr && hit_id),
        .wdata      (io_wdata),
        .data_q     (data_q),
        .chip_id_q  (chip_id_q),
        .pri_cfg_nxt(pri_cfg_nxt),
        .sec_cfg_nxt(sec_cfg_nxt)
    );

    dcc_chan_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .data_wr    (io_wr && hit_data),
        .pri_cfg_nxt(pri_cfg_nxt),
        .sec_cfg_nxt(sec_cfg_nxt),
        .pri_en     (pri_en),
        .sec_en     (sec_en)
    );

    assign en_vec = {sec_en, pri_en};

    for (genvar ch = 0; ch < NCHAN; ch++) begin : g_chan
        dcc_chan_decode #(
            .ADDR_W  (ADDR_W),
            .SPAN_LOG(SPAN_LOG),
            .CMD_BASE(ADDR_W'(cmd_base(ch))),
            .CTL_ADDR(ADDR_W'(ctl_addr(ch)))
        ) u_dec (
            .en    (en_vec[ch]),
            .access(io_rd || io_wr),
            .addr  (io_addr),
            .cmd_cs(cmd_vec[ch]),
            .ctl_cs(ctl_vec[ch])
        );
    end

    assign pri_cmd_cs = cmd_vec[0];
    assign pri_ctl_cs = ctl_vec[0];
    assign sec_cmd_cs = cmd_vec[1];
    assign sec_ctl_cs = ctl_vec[1];

    always_comb begin
        if (hit_id)        io_rdata = chip_id_q;
        else if (hit_data) io_rdata = data_q;
        else               io_rdata = '1;   // index port and unmapped
    end

    // R9: at most one select asserted per access
    p_cs_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pri_cmd_cs, pri_ctl_cs, sec_cmd_cs, sec_ctl_cs}));

    // R1: enables low in the cycle after reset
    p_reset_off_r1: assert property (@(posedge clk)
        !rst_n |=> (!pri_en && !sec_en));

endmodule

// File: tb/dcc_port_top_test.sv
module dcc_port_top_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        pri_en, sec_en, pri_cmd_cs, pri_ctl_cs, sec_cmd_cs, sec_ctl_cs;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dcc_port_top uut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .pri_en(pri_en), .sec_en(sec_en),
        .pri_cmd_cs(pri_cmd_cs), .pri_ctl_cs(pri_ctl_cs),
        .sec_cmd_cs(sec_cmd_cs), .sec_ctl_cs(sec_ctl_cs)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(posedge clk);
        #1;
        io_wr = 1'b0;
    endtask

    task automatic io_read_check(input logic [15:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1;
        check(req, io_rdata, exp);
        io_rd = 1'b0;
    endtask

    task automatic cfg_write(input logic [7:0] idx, input logic [7:0] d);
        io_write(16'h00F8, idx);
        io_write(16'h00FC, d);
    endtask

    task automatic check_en(input logic p, input logic s, input string req);
        check({req, " pri_en"}, pri_en, p);
        check({req, " sec_en"}, sec_en, s);
    endtask

    task automatic check_cs(input logic [15:0] a, input logic [3:0] exp, input string req);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1;
        check(req, {pri_cmd_cs, pri_ctl_cs, sec_cmd_cs, sec_ctl_cs}, exp);
        io_rd = 1'b0;
    endtask

    task automatic t_reset_state;
        check_en(1'b0, 1'b0, "R1 reset");
        io_read_check(16'h00F4, 8'h00, "R1 chip id");
        io_write(16'h00F8, 8'h01); io_read_check(16'h00FC, 8'h02, "R1 idx01");
        io_write(16'h00F8, 8'h08); io_read_check(16'h00FC, 8'hFF, "R1 idx08");
        io_write(16'h00F8, 8'h09); io_read_check(16'h00FC, 8'h41, "R1 idx09");
        io_write(16'h00F8, 8'h34); io_read_check(16'h00FC, 8'hFF, "R1 idx34");
        io_write(16'h00F8, 8'h35); io_read_check(16'h00FC, 8'h01, "R1 idx35");
        io_write(16'h00F8, 8'h02); io_read_check(16'h00FC, 8'h00, "R1 idx02");
        check_cs(16'h01F0, 4'b0000, "R8 no cs when off");
    endtask

    task automatic t_ports;
        io_write(16'h00F4, 8'h30);
        io_read_check(16'h00F4, 8'h30, "R2 chip id");
        io_read_check(16'h00F8, 8'hFF, "R3 index read");
        cfg_write(8'h7A, 8'hA5);
        io_read_check(16'h00FC, 8'hA5, "R4 data readback");
        io_write(16'h00F8, 8'h7B);
        io_read_check(16'h00FC, 8'h00, "R4 other index");
        io_read_check(16'h0123, 8'hFF, "R10 unmapped");
        check_en(1'b0, 1'b0, "R7 after port writes");
    endtask

    task automatic t_primary;
        cfg_write(8'h01, 8'h03);
        check_en(1'b1, 1'b0, "R5 R6 pri on masked sec");
        check_cs(16'h01F0, 4'b1000, "R8 cmd low");
        check_cs(16'h01F7, 4'b1000, "R8 cmd high");
        check_cs(16'h01F8, 4'b0000, "R8 cmd past end");
        check_cs(16'h03F6, 4'b0100, "R8 ctl");
        check_cs(16'h03F7, 4'b0000, "R8 ctl neighbour");
        check_cs(16'h0170, 4'b0000, "R9 sec off");
    endtask

    task automatic t_secondary;
        cfg_write(8'h35, 8'h00);
        check_en(1'b1, 1'b1, "R6 mask clear");
        check_cs(16'h0170, 4'b0010, "R9 cmd low");
        check_cs(16'h0177, 4'b0010, "R9 cmd high");
        check_cs(16'h0376, 4'b0001, "R9 ctl");
        check_cs(16'h0178, 4'b0000, "R9 past end");
        io_write(16'h00FC, 8'h40);
        check_en(1'b1, 1'b0, "R6 bit6 masks");
        io_write(16'h00FC, 8'hBE);
        check_en(1'b1, 1'b1, "R6 other bits ignored");
    endtask

    task automatic t_drop_and_hold;
        cfg_write(8'h01, 8'hFE);
        check_en(1'b0, 1'b0, "R5 pri drop takes sec");
        check_cs(16'h0170, 4'b0000, "R9 off after drop");
        io_write(16'h00FC, 8'h01);
        check_en(1'b1, 1'b1, "R5 R6 re-evaluate");
        io_write(16'h00F8, 8'h01);
        io_write(16'h00F4, 8'h00);
        io_read_check(16'h00FC, 8'h01, "R7 read");
        check_en(1'b1, 1'b1, "R7 hold");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_ports();
        t_primary();
        t_secondary();
        t_drop_and_hold();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule